// File: doc/BRIEF.md
# Sprite Pixel Shifter and Collision Detector

This block sits at the end of a tile-and-sprite video pipeline. During the line fetch phase the attribute and pattern fetch logic writes up to four sprites into the block's slots: each slot holds a horizontal start position, a four-bit colour, an early-shift flag and a 16-bit pattern shift register. During the visible part of the next line the block is stepped once per pixel. Every slot whose start position has been reached presents the top bit of its pattern and shifts left. The block picks the winning sprite pixel, or falls back to the tile layer's pixel, and registers a 4-bit colour index for the colour converter downstream.

The tile layer's pixel is formed from a pattern bit and a colour byte; a zero background colour falls through to the backdrop colour, and in text mode both colours come from the backdrop register instead. Whenever two sprites present a set pattern bit on the same dot, a sticky collision flag is raised. It stays set until the status read strobe clears it.

Top module: `spx_sprite_mixer`

## Requirements
- R1: While reset is asserted and after it is released, `pix_color` is 0 and `collide` is 0, and every slot is inactive.
- R2: With no opaque sprite pixel and `text_mode` low, the pixel is `bg_colors[7:4]` when `bg_bit` is 1 and `bg_colors[3:0]` when `bg_bit` is 0.
- R3: In that non-text case, a selected low nibble of 0 is replaced by `backdrop[3:0]`; a high nibble of 0 is kept as 0.
- R4: With `text_mode` high and no opaque sprite pixel, the pixel is `backdrop[7:4]` for `bg_bit` 1 and `backdrop[3:0]` for `bg_bit` 0; `bg_colors` is ignored.
- R5: A slot becomes active when its X byte is loaded (`ld_kind` 0). On each `pix_en` cycle where the signed pixel position is at or past the slot's start, bit 15 of its shifter is its pixel and the shifter moves left by one.
- R6: `ld_kind` 2 writes the byte into shifter bits 15:8 and zeroes bits 7:0. `ld_kind` 3 writes bits 7:0 only when `size_big` is 1, and is ignored otherwise.
- R7: `ld_kind` 1 loads the attribute byte: bits 3:0 are the sprite colour, and bit 7 set moves the start position 32 pixels to the left.
- R8: A `pix_x` value above 294 is treated as `pix_x` − 512, so sprites can start left of pixel 0.
- R9: The lowest-numbered slot with a set pixel and a non-zero colour wins the dot. A set pixel with colour 0 is transparent.
- R10: Two or more slots with a set pixel on one `pix_en` dot set `collide`, regardless of colour. It stays set until `stat_rd`; when a new collision arrives in the same cycle as `stat_rd`, the set wins.
- R11: `line_clear` makes all slots inactive and empties their shifters. It takes precedence over a load in the same cycle.
- R12: `pix_color` changes only on the clock edge where `pix_en` is high, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_clear | input | 1 | Deactivates all slots before a new line is loaded |
| ld_valid | input | 1 | Load strobe for one slot field |
| ld_slot | input | 2 | Slot index for the load |
| ld_kind | input | 2 | 0 X byte, 1 attribute byte, 2 first pattern byte, 3 second pattern byte |
| ld_data | input | 8 | Load data byte |
| size_big | input | 1 | 16-pixel sprite width when set |
| pix_en | input | 1 | Advances one pixel |
| pix_x | input | 9 | Pixel X counter |
| bg_bit | input | 1 | Tile layer pattern bit for this pixel |
| bg_colors | input | 8 | Tile colour byte, foreground high nibble, background low nibble |
| backdrop | input | 8 | Colour register, text foreground high nibble, backdrop low nibble |
| text_mode | input | 1 | Selects text mode colour source |
| stat_rd | input | 1 | Status read strobe, clears the collision flag |
| pix_color | output | 4 | Registered colour index of the last pixel |
| collide | output | 1 | Sticky sprite collision flag |

## Verification
The colour and the collision result for a pixel are registered on the same edge that samples `pix_en`, so both are due one clock after the pixel is presented. The bench drives each pixel between two falling edges and reads the outputs at the second falling edge, where they are settled. A load or a `line_clear` takes effect at the next rising edge, and a `stat_rd` clears `collide` one clock later. Because the shifters only move on pixels that have reached a slot's start, the bench steps `pix_x` through every position from the start to the checked dot rather than jumping ahead.

// File: rtl/spx_pkg.sv
package spx_pkg;

    // Field selector on the load bus.
    typedef enum logic [1:0] {
        LD_XPOS   = 2'd0,
        LD_ATTR   = 2'd1,
        LD_PAT_HI = 2'd2,
        LD_PAT_LO = 2'd3
    } ld_kind_e;

    localparam int unsigned PIX_W      = 9;          // pixel counter width
    localparam int unsigned SPOS_W     = PIX_W + 1;  // signed position width
    localparam int unsigned WRAP_LIMIT = 294;        // above this, counter is negative
    localparam int unsigned EARLY_SHIFT = 32;        // early-shift distance in pixels
    localparam int unsigned PAT_W      = 16;         // pattern shifter width
    localparam int unsigned COL_W      = 4;          // colour index width

endpackage

// File: rtl/spx_slot.sv
module spx_slot
    import spx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     ld_en,
    input  ld_kind_e                 ld_kind,
    input  logic [7:0]               ld_data,
    input  logic                     size_big,
    input  logic                     pix_en,
    input  logic signed [SPOS_W-1:0] pos,
    output logic                     pix_bit,
    output logic [COL_W-1:0]         color,
    output logic                     active
);

    typedef struct packed {
        logic             act;
        logic             early;
        logic [7:0]       xpos;
        logic [COL_W-1:0] col;
        logic [PAT_W-1:0] shf;
    } slot_t;

    localparam int unsigned HALF = PAT_W / 2;

    slot_t st_q, st_d;
    logic signed [SPOS_W-1:0] start_pos;
    logic                     reached;

    always_comb begin
        start_pos = $signed({{(SPOS_W-8){1'b0}}, st_q.xpos});
        if (st_q.early) begin
            start_pos = start_pos - $signed(SPOS_W'(EARLY_SHIFT));
        end
        reached = st_q.act && (pos >= start_pos);
    end

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.act = 1'b0;
            st_d.shf = '0;
        end else if (ld_en) begin
            unique case (ld_kind)
                LD_XPOS: begin
                    st_d.xpos  = ld_data;
                    st_d.act   = 1'b1;
                    st_d.early = 1'b0;
                end
                LD_ATTR: begin
                    st_d.early = ld_data[7];
                    st_d.col   = ld_data[COL_W-1:0];
                end
                LD_PAT_HI: begin
                    st_d.shf = {ld_data, {HALF{1'b0}}};
                end
                LD_PAT_LO: begin
                    if (size_big) begin
                        st_d.shf[HALF-1:0] = ld_data;
                    end
                end
                default: st_d = st_q;
            endcase
        end else if (pix_en && reached) begin
            st_d.shf = {st_q.shf[PAT_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_bit = reached && st_q.shf[PAT_W-1];
    assign color   = st_q.col;
    assign active  = st_q.act;

endmodule

// File: rtl/spx_select.sv
module spx_select
    import spx_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0]            bits,
    input  logic [NUM_SLOTS-1:0][COL_W-1:0] colors,
    output logic                            hit,
    output logic [COL_W-1:0]                win_color,
    output logic                            multi
);

    localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1);

    logic [CNT_W-1:0] set_cnt;

    always_comb begin
        hit       = 1'b0;
        win_color = '0;
        set_cnt   = '0;
        // Walk from the highest slot down so the lowest opaque slot is the last to write.
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (bits[i] && (colors[i] != '0)) begin
                hit       = 1'b1;
                win_color = colors[i];
            end
            set_cnt = set_cnt + CNT_W'(bits[i]);
        end
        multi = (set_cnt > CNT_W'(1));
    end

endmodule

// File: rtl/spx_sprite_mixer.sv
module spx_sprite_mixer
    import spx_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_clear,
    input  logic              ld_valid,
    input  logic [SLOT_W-1:0] ld_slot,
    input  logic [1:0]        ld_kind,
    input  logic [7:0]        ld_data,
    input  logic              size_big,
    input  logic              pix_en,
    input  logic [PIX_W-1:0]  pix_x,
    input  logic              bg_bit,
    input  logic [7:0]        bg_colors,
    input  logic [7:0]        backdrop,
    input  logic              text_mode,
    input  logic              stat_rd,
    output logic [COL_W-1:0]  pix_color,
    output logic              collide
);

    typedef struct packed {
        logic [COL_W-1:0] color;
        logic             coll;
    } out_t;

    out_t out_q, out_d;

    logic signed [SPOS_W-1:0]       pos;
    logic [NUM_SLOTS-1:0]           slot_bit;
    logic [NUM_SLOTS-1:0]           slot_act;
    logic [NUM_SLOTS-1:0][COL_W-1:0] slot_col;
    logic                           spr_hit;
    logic [COL_W-1:0]               spr_color;
    logic                           spr_multi;
    logic [COL_W-1:0]               fg_col;
    logic [COL_W-1:0]               bk_col;
    logic [COL_W-1:0]               tile_col;

    // Counter values past the visible span stand for positions left of zero.
    always_comb begin
        if (pix_x > PIX_W'(WRAP_LIMIT)) begin
            pos = $signed({1'b1, pix_x});
        end else begin
            pos = $signed({1'b0, pix_x});
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        spx_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (line_clear),
            .ld_en    (ld_valid && (ld_slot == SLOT_W'(g))),
            .ld_kind  (ld_kind_e'(ld_kind)),
            .ld_data  (ld_data),
            .size_big (size_big),
            .pix_en   (pix_en),
            .pos      (pos),
            .pix_bit  (slot_bit[g]),
            .color    (slot_col[g]),
            .active   (slot_act[g])
        );
    end

    spx_select #(.NUM_SLOTS(NUM_SLOTS)) u_select (
        .bits      (slot_bit),
        .colors    (slot_col),
        .hit       (spr_hit),
        .win_color (spr_color),
        .multi     (spr_multi)
    );

    // Tile layer colour.
    always_comb begin
        if (text_mode) begin
            fg_col = backdrop[7:4];
            bk_col = backdrop[3:0];
        end else begin
            fg_col = bg_colors[7:4];
            bk_col = (bg_colors[3:0] == '0) ? backdrop[3:0] : bg_colors[3:0];
        end
        tile_col = bg_bit ? fg_col : bk_col;
    end

    always_comb begin
        out_d = out_q;
        if (stat_rd) begin
            out_d.coll = 1'b0;
        end
        if (pix_en) begin
            out_d.color = spr_hit ? spr_color : tile_col;
            if (spr_multi) begin
                out_d.coll = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pix_color = out_q.color;
    assign collide   = out_q.coll;

endmodule

// File: rtl/spx_mixer_chk.sv
module spx_mixer_chk #(
    parameter int unsigned NUM_SLOTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 line_clear,
    input logic                 pix_en,
    input logic                 stat_rd,
    input logic [3:0]           pix_color,
    input logic                 collide,
    input logic [NUM_SLOTS-1:0] slot_act
);

    // R1: reset leaves outputs and slots cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pix_color == 4'd0 && !collide && slot_act == '0));

    // R10: flag is sticky without a status read
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        collide && !stat_rd |=> collide);

    // R10: status read with no pixel clears the flag
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !pix_en |=> !collide);

    // R10: a new collision only appears on a pixel step
    a_r10_rise_on_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        !collide && !pix_en |=> !collide);

    // R11: line clear empties all slots
    a_r11_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
        line_clear |=> (slot_act == '0));

    // R12: colour holds between pixel steps
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pix_color));

endmodule

bind spx_sprite_mixer spx_mixer_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_clear (line_clear),
    .pix_en     (pix_en),
    .stat_rd    (stat_rd),
    .pix_color  (pix_color),
    .collide    (collide),
    .slot_act   (slot_act)
);

// File: tb/tb_spx_sprite_mixer.sv
module tb_spx_sprite_mixer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 8;

    // {text_mode, bg_bit, bg_colors, backdrop, expected colour}
    localparam logic [21:0] BG_VEC [NVEC] = '{
        {1'b0, 1'b1, 8'h5A, 8'h3E, 4'h5},   // R2 foreground nibble
        {1'b0, 1'b0, 8'h5A, 8'h3E, 4'hA},   // R2 background nibble
        {1'b0, 1'b0, 8'h50, 8'h3E, 4'hE},   // R3 zero background -> backdrop
        {1'b0, 1'b1, 8'h0A, 8'h3E, 4'h0},   // R3 zero foreground kept
        {1'b1, 1'b1, 8'h5A, 8'h3E, 4'h3},   // R4 text foreground
        {1'b1, 1'b0, 8'h5A, 8'h3E, 4'hE},   // R4 text backdrop
        {1'b1, 1'b0, 8'h5A, 8'h30, 4'h0},   // R4 text backdrop zero
        {1'b0, 1'b0, 8'h17, 8'h3E, 4'h7}    // R2 plain background
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_clear = 1'b0;
    logic       ld_valid = 1'b0;
    logic [1:0] ld_slot = '0;
    logic [1:0] ld_kind = '0;
    logic [7:0] ld_data = '0;
    logic       size_big = 1'b0;
    logic       pix_en = 1'b0;
    logic [8:0] pix_x = '0;
    logic       bg_bit = 1'b0;
    logic [7:0] bg_colors = 8'h13;
    logic [7:0] backdrop = 8'h3E;
    logic       text_mode = 1'b0;
    logic       stat_rd = 1'b0;
    logic [3:0] pix_color;
    logic       collide;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spx_sprite_mixer dut (
        .clk(clk), .rst_n(rst_n), .line_clear(line_clear), .ld_valid(ld_valid),
        .ld_slot(ld_slot), .ld_kind(ld_kind), .ld_data(ld_data), .size_big(size_big),
        .pix_en(pix_en), .pix_x(pix_x), .bg_bit(bg_bit), .bg_colors(bg_colors),
        .backdrop(backdrop), .text_mode(text_mode), .stat_rd(stat_rd),
        .pix_color(pix_color), .collide(collide)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load(input int slot, input int kind, input int data);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_slot  = 2'(slot);
        ld_kind  = 2'(kind);
        ld_data  = 8'(data);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic sprite(input int slot, input int x, input int attr, input int hi);
        load(slot, 0, x);
        load(slot, 1, attr);
        load(slot, 2, hi);
    endtask

    task automatic pix(input int x);
        @(negedge clk);
        pix_x  = 9'(x);
        pix_en = 1'b1;
        @(negedge clk);
        pix_en = 1'b0;
    endtask

    task automatic clr_line();
        @(negedge clk);
        line_clear = 1'b1;
        @(negedge clk);
        line_clear = 1'b0;
    endtask

    task automatic rd_status();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 colour in reset", pix_color, 0);
        check("R1 collide in reset", collide, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 colour after reset", pix_color, 0);
        check("R1 collide after reset", collide, 0);
        pix(10);   // no slot active yet
        check("R1 slots inactive after reset", pix_color, 3);

        // Background merge table (R2 R3 R4)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            text_mode = BG_VEC[i][21];
            bg_bit    = BG_VEC[i][20];
            bg_colors = BG_VEC[i][19:12];
            backdrop  = BG_VEC[i][11:4];
            pix(20 + i);
            check($sformatf("R2/R3/R4 vector %0d", i), pix_color, int'(BG_VEC[i][3:0]));
        end
        @(negedge clk);
        text_mode = 1'b0; bg_bit = 1'b0; bg_colors = 8'h13; backdrop = 8'h3E;

        // R5 pattern shifting from the start position
        clr_line();
        sprite(0, 10, 8'h05, 8'hA0);
        pix(8);  check("R5 before start", pix_color, 3);
        pix(9);  check("R5 before start", pix_color, 3);
        pix(10); check("R5 first pixel", pix_color, 5);
        pix(11); check("R5 shifted zero", pix_color, 3);
        pix(12); check("R5 shifted one", pix_color, 5);
        pix(13); check("R5 shifted zero", pix_color, 3);

        // R12 hold without pixel step
        pix(14);
        @(negedge clk);
        bg_colors = 8'h19;
        repeat (3) @(negedge clk);
        check("R12 colour held", pix_color, 3);
        bg_colors = 8'h13;

        // R6 wide sprite: second byte reaches the 16th pixel
        clr_line();
        size_big = 1'b1;
        sprite(1, 10, 8'h06, 8'h00);
        load(1, 3, 8'h01);
        for (int x = 10; x < 25; x++) pix(x);
        check("R6 wide pixel 15", pix_color, 3);
        pix(25); check("R6 wide pixel 16", pix_color, 6);

        // R6 narrow: second byte ignored
        clr_line();
        size_big = 1'b0;
        sprite(1, 10, 8'h06, 8'h00);
        load(1, 3, 8'h01);
        for (int x = 10; x < 26; x++) pix(x);
        check("R6 narrow ignores low byte", pix_color, 3);

        // R7 early shift moves the start 32 left
        clr_line();
        sprite(2, 40, 8'h87, 8'h80);
        pix(7); check("R7 before early start", pix_color, 3);
        pix(8); check("R7 early start", pix_color, 7);

        // R8 counter wrap to negative positions
        clr_line();
        sprite(3, 20, 8'h8B, 8'h80);
        pix(490); check("R8 -22 before -12", pix_color, 3);
        pix(500); check("R8 -12 reached", pix_color, 11);

        // R9 and R10 priority and collision
        clr_line();
        rd_status();
        sprite(0, 10, 8'h04, 8'h80);
        sprite(1, 10, 8'h09, 8'h80);
        pix(9);  check("R10 no overlap yet", collide, 0);
        pix(10); check("R9 lower slot wins", pix_color, 4);
        check("R10 collision set", collide, 1);
        pix(11); check("R10 collision sticky", collide, 1);
        rd_status();
        check("R10 status read clears", collide, 0);

        // R9 colour 0 is transparent but still collides
        clr_line();
        sprite(0, 10, 8'h00, 8'h80);
        sprite(1, 10, 8'h09, 8'h80);
        pix(10);
        check("R9 transparent skipped", pix_color, 9);
        check("R10 transparent collides", collide, 1);

        // R10 set wins over a same-cycle status read
        clr_line();
        sprite(2, 10, 8'h0C, 8'h80);
        sprite(3, 10, 8'h0D, 8'h80);
        @(negedge clk);
        pix_x = 9'd10; pix_en = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        pix_en = 1'b0; stat_rd = 1'b0;
        check("R10 set beats read", collide, 1);
        check("R9 slot 2 over slot 3", pix_color, 12);
        rd_status();

        // R11 line clear removes loaded sprites
        clr_line();
        sprite(0, 10, 8'h05, 8'h80);
        clr_line();
        pix(10);
        check("R11 cleared slot silent", pix_color, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule